// File: doc/BRIEF.md
# 32-Pin GPIO Port Controller

A general-purpose I/O port for 32 pins, reached through a simple 32-bit register bus. Software drives pins through an output-data word and a direction word (a direction bit of 1 makes the pin an output). It reads pins through a sampled pad word. Each input pin can raise an event on a low level, a high level, a rising edge or a falling edge. An optional per-pin any-edge select overrides that choice. Events latch into a status word that software clears by writing ones. The masked status drives one interrupt line, or two lines, one per half-word of pins.

The bus completes every access in the cycle it is presented, so ready is tied high. Read data is combinational from the registers. A write takes effect at the next rising clock edge. Pads are registered once inside the block, and edge detection compares that sample with the one taken a cycle earlier. An access to an offset outside the map returns zero, changes nothing and raises a one-cycle error flag.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads zero, pin_out and pin_oe are zero and both interrupt lines are low.
- R2: A read at offset 0x00 returns, per pin, the output-data bit where the direction bit is 1 and the sampled pad bit where it is 0. A write at offset 0x00 sets the output-data word.
- R3: A read at offset 0x08 returns the sampled pads with all output pins forced to zero. pin_in is sampled at each rising edge.
- R4: Pin n's 2-bit event mode sits at bits [2n+1:2n] of offset 0x0C for pins 0-15, and at bits [2(n-16)+1:2(n-16)] of offset 0x10 for pins 16-31. Each word is written and read on its own. The mode codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: When bit n of the any-edge word at offset 0x1C is 1, pin n raises an event on either edge, whatever its mode code.
- R6: A pin whose direction bit at offset 0x04 is 1 never raises an event, whatever its pad does.
- R7: A write at offset 0x18 clears each status bit written as 1 and leaves bits written as 0 alone. An event in the same cycle as the clear leaves the bit set, so a level event stays set while its level persists.
- R8: With the split option off, irq_lo is high exactly when status AND mask (offset 0x14) is nonzero, and irq_hi stays low.
- R9: With the split option on, irq_lo reflects status AND mask for pins 0-15 and irq_hi reflects it for pins 16-31.
- R10: When the any-edge word is built out, offset 0x1C reads zero, writes to it are ignored and edge events follow the mode codes alone.
- R11: rsp_ready is always high. A misaligned offset, or one at 0x20 or above, reads zero, changes no register and raises addr_err in that same cycle. A write at offset 0x08 changes nothing and raises no error.
- R12: pin_out equals the output-data word and pin_oe equals the direction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle, zero when not reading |
| rsp_ready | output | 1 | Access accepted, always high |
| addr_err | output | 1 | Access to an unmapped or misaligned offset |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Driven pad levels |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt, all pins or pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 in split mode |

## Verification
Two instances receive the same stimulus. One has the any-edge word and a single interrupt line, and the other has neither. Where the two sets of status bits and interrupt lines differ, that difference separates the any-edge override from the mode codes, and split lines from the combined line. Pad patterns that change only some low pins are run under each of the four mode codes, with the upper pins as outputs. This shows rising from falling, level from edge, and input pins from outputs. Partial clears, and a clear that lands while a level event is still active, separate the write-one-to-clear rule from a plain register write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned CFG_W   = 2 * WORD_W;
  localparam int unsigned REG_CNT = 8;

  // Word index (byte offset / 4) of each register.
  typedef enum logic [2:0] {
    IDX_DATA   = 3'd0,
    IDX_DIR    = 3'd1,
    IDX_PAD    = 3'd2,
    IDX_CFG_LO = 3'd3,
    IDX_CFG_HI = 3'd4,
    IDX_MASK   = 3'd5,
    IDX_STAT   = 3'd6,
    IDX_EDGE   = 3'd7
  } reg_idx_e;

  // Per-pin event mode code.
  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_RISE = 2'b10,
    MODE_FALL = 2'b11
  } pin_mode_e;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   dir_i,
  input  logic [2*PINS-1:0] cfg_i,
  input  logic [PINS-1:0]   edge_i,
  output logic [PINS-1:0]   pad_o,
  output logic [PINS-1:0]   evt_o
);

  logic [PINS-1:0] pad_q;
  logic [PINS-1:0] pad_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q      <= '0;
      pad_prev_q <= '0;
    end else begin
      pad_prev_q <= pad_q;
      pad_q      <= pin_in;
    end
  end

  assign pad_o = pad_q;

  for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
    logic [1:0] mode_w;
    logic       rise_w;
    logic       fall_w;
    logic       mode_hit;

    assign mode_w = cfg_i[2*gi +: 2];
    assign rise_w = pad_q[gi] & ~pad_prev_q[gi];
    assign fall_w = ~pad_q[gi] & pad_prev_q[gi];

    always_comb begin
      case (pin_mode_e'(mode_w))
        MODE_LOW:  mode_hit = ~pad_q[gi];
        MODE_HIGH: mode_hit = pad_q[gi];
        MODE_RISE: mode_hit = rise_w;
        MODE_FALL: mode_hit = fall_w;
        default:   mode_hit = 1'b0;
      endcase
    end

    assign evt_o[gi] = ~dir_i[gi] & (edge_i[gi] ? (rise_w | fall_w) : mode_hit);
  end

  // R6
  input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & dir_i) == '0);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          HAS_ANY_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] pad_i,
  input  logic [WORD_W-1:0] evt_i,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              addr_err,
  output logic [WORD_W-1:0] dr_o,
  output logic [WORD_W-1:0] dir_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] isr_o,
  output logic [WORD_W-1:0] edge_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               aligned;
  logic               high_zero;
  logic               in_map;
  logic               wr_ok;
  logic               rd_ok;
  reg_idx_e           sel;
  logic [REG_CNT-1:0] wr_hit;

  assign word_idx = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign sel      = reg_idx_e'(word_idx[2:0]);

  if (IDX_W > 3) begin : g_upper
    assign high_zero = ~|word_idx[IDX_W-1:3];
  end else begin : g_no_upper
    assign high_zero = 1'b1;
  end

  assign in_map   = aligned & high_zero;
  assign wr_ok    = req_valid & req_write & in_map;
  assign rd_ok    = req_valid & ~req_write & in_map;
  assign addr_err = req_valid & ~in_map;

  always_comb begin
    wr_hit      = '0;
    wr_hit[sel] = wr_ok;
  end

  // Register state and next-state
  logic [WORD_W-1:0] dr_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, isr_q, edge_q;
  logic [WORD_W-1:0] isr_d;
  logic [WORD_W-1:0] clr_bits;

  assign clr_bits = wr_hit[IDX_STAT] ? req_wdata : '0;
  assign isr_d    = (isr_q & ~clr_bits) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q     <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      isr_q    <= '0;
    end else begin
      if (wr_hit[IDX_DATA])   dr_q     <= req_wdata;
      if (wr_hit[IDX_DIR])    dir_q    <= req_wdata;
      if (wr_hit[IDX_CFG_LO]) cfg_lo_q <= req_wdata;
      if (wr_hit[IDX_CFG_HI]) cfg_hi_q <= req_wdata;
      if (wr_hit[IDX_MASK])   mask_q   <= req_wdata;
      isr_q <= isr_d;
    end
  end

  if (HAS_ANY_EDGE) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                edge_q <= '0;
      else if (wr_hit[IDX_EDGE]) edge_q <= req_wdata;
    end
  end else begin : g_no_edge
    assign edge_q = '0;
  end

  // Readback
  always_comb begin
    rsp_rdata = '0;
    if (rd_ok) begin
      case (sel)
        IDX_DATA:   rsp_rdata = (dr_q & dir_q) | (pad_i & ~dir_q);
        IDX_DIR:    rsp_rdata = dir_q;
        IDX_PAD:    rsp_rdata = pad_i & ~dir_q;
        IDX_CFG_LO: rsp_rdata = cfg_lo_q;
        IDX_CFG_HI: rsp_rdata = cfg_hi_q;
        IDX_MASK:   rsp_rdata = mask_q;
        IDX_STAT:   rsp_rdata = isr_q;
        IDX_EDGE:   rsp_rdata = edge_q;
        default:    rsp_rdata = '0;
      endcase
    end
  end

  assign dr_o   = dr_q;
  assign dir_o  = dir_q;
  assign cfg_o  = {cfg_hi_q, cfg_lo_q};
  assign mask_o = mask_q;
  assign isr_o  = isr_q;
  assign edge_o = edge_q;

  // R7
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[IDX_STAT] |=> ((isr_q & $past(req_wdata)) == ($past(evt_i) & $past(req_wdata))));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[IDX_STAT] |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

  // R3
  pad_read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && sel == IDX_PAD) |-> ((rsp_rdata & dir_q) == '0));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (rsp_rdata == '0));

  if (!HAS_ANY_EDGE) begin : g_edge_chk
    // R10
    edge_absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_W'(7 * 4)) |-> (rsp_rdata == '0));
  end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine
  import gpio_pkg::*;
#(
  parameter bit SPLIT_IRQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] isr_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);

  logic [WORD_W-1:0] pending;
  assign pending = isr_i & mask_i;

  if (SPLIT_IRQ) begin : g_split
    assign irq_lo_o = |pending[HALF_W-1:0];
    assign irq_hi_o = |pending[WORD_W-1:HALF_W];

    // R9
    irq_hi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi_o |-> (|isr_i[WORD_W-1:HALF_W]));
  end else begin : g_single
    assign irq_lo_o = |pending;
    assign irq_hi_o = 1'b0;
  end

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo_o || irq_hi_o) |-> (mask_i != '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          HAS_ANY_EDGE = 1'b1,
  parameter bit          SPLIT_IRQ    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_ready,
  output logic              addr_err,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  logic [WORD_W-1:0] dr_w, dir_w, mask_w, isr_w, edge_w, pad_w, evt_w;
  logic [CFG_W-1:0]  cfg_w;

  gpio_regfile #(
    .ADDR_W      (ADDR_W),
    .HAS_ANY_EDGE(HAS_ANY_EDGE)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .pad_i    (pad_w),
    .evt_i    (evt_w),
    .rsp_rdata(rsp_rdata),
    .addr_err (addr_err),
    .dr_o     (dr_w),
    .dir_o    (dir_w),
    .cfg_o    (cfg_w),
    .mask_o   (mask_w),
    .isr_o    (isr_w),
    .edge_o   (edge_w)
  );

  gpio_evt_detect #(
    .PINS(WORD_W)
  ) evt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .dir_i (dir_w),
    .cfg_i (cfg_w),
    .edge_i(edge_w),
    .pad_o (pad_w),
    .evt_o (evt_w)
  );

  gpio_irq_combine #(
    .SPLIT_IRQ(SPLIT_IRQ)
  ) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .isr_i   (isr_w),
    .mask_i  (mask_w),
    .irq_lo_o(irq_lo),
    .irq_hi_o(irq_hi)
  );

  assign rsp_ready = 1'b1;
  assign pin_out   = dr_w;
  assign pin_oe    = dir_w;

  // R11
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> req_valid);

  // R12
  oe_holds_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == ADDR_W'(4)) |=> $stable(pin_oe));

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v = 1'b0, w = 1'b0;
  logic [AW-1:0] a = '0;
  logic [31:0]   d = '0, pin = '0;

  logic [31:0] rd_a, rd_b, po_a, po_b, oe_a, oe_b;
  logic        rdy_a, rdy_b, err_a, err_b, lo_a, lo_b, hi_a, hi_b;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.ADDR_W(AW), .HAS_ANY_EDGE(1'b1), .SPLIT_IRQ(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(a),
    .req_wdata(d), .rsp_rdata(rd_a), .rsp_ready(rdy_a), .addr_err(err_a),
    .pin_in(pin), .pin_out(po_a), .pin_oe(oe_a), .irq_lo(lo_a), .irq_hi(hi_a));

  gpio_port_ctrl #(.ADDR_W(AW), .HAS_ANY_EDGE(1'b0), .SPLIT_IRQ(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(a),
    .req_wdata(d), .rsp_rdata(rd_b), .rsp_ready(rdy_b), .addr_err(err_b),
    .pin_in(pin), .pin_out(po_b), .pin_oe(oe_b), .irq_lo(lo_b), .irq_hi(hi_b));

  int checks = 0;
  int errors = 0;

  // Behavioural reference, index 0 = dut_i, 1 = dut_b_i
  logic [31:0] m_dr[2], m_dir[2], m_psr[2], m_prev[2], m_mask[2], m_isr[2], m_edge[2];
  logic [63:0] m_cfg[2];
  bit          has_edge[2] = '{1'b1, 1'b0};
  bit          split[2]    = '{1'b0, 1'b1};

  logic [31:0] cap_rd[2];
  logic        cap_err[2], cap_lo[2], cap_hi[2];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_dr[k] = 0; m_dir[k] = 0; m_psr[k] = 0; m_prev[k] = 0;
      m_mask[k] = 0; m_isr[k] = 0; m_edge[k] = 0; m_cfg[k] = 0;
    end
  endtask

  function automatic logic [31:0] model_evt(int k);
    logic [31:0] e = 0;
    for (int p = 0; p < 32; p++) begin
      int  code = int'(m_cfg[k] >> (2 * p)) & 3;
      bit  now  = m_psr[k][p];
      bit  was  = m_prev[k][p];
      if (m_dir[k][p]) e[p] = 0;
      else if (m_edge[k][p]) e[p] = (now != was);
      else if (code == 0) e[p] = !now;
      else if (code == 1) e[p] = now;
      else if (code == 2) e[p] = now && !was;
      else e[p] = !now && was;
    end
    return e;
  endfunction

  function automatic bit mapped(logic [AW-1:0] ad);
    return (ad[1:0] == 0) && (ad < 6'h20);
  endfunction

  function automatic logic [31:0] model_read(int k, logic [AW-1:0] ad);
    case (ad)
      6'h00: return (m_dr[k] & m_dir[k]) | (m_psr[k] & ~m_dir[k]);
      6'h04: return m_dir[k];
      6'h08: return m_psr[k] & ~m_dir[k];
      6'h0C: return m_cfg[k][31:0];
      6'h10: return m_cfg[k][63:32];
      6'h14: return m_mask[k];
      6'h18: return m_isr[k];
      6'h1C: return has_edge[k] ? m_edge[k] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(int k, logic [AW-1:0] ad);
    case (ad)
      6'h00: return "R2";
      6'h04: return "R12";
      6'h08: return "R3";
      6'h0C, 6'h10: return "R4";
      6'h14: return "R8";
      6'h18: return "R7";
      6'h1C: return has_edge[k] ? "R5" : "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_clock();
    for (int k = 0; k < 2; k++) begin
      logic [31:0] ev  = model_evt(k);
      logic [31:0] clr = (v && w && a == 6'h18) ? d : 32'h0;
      m_isr[k]  = (m_isr[k] & ~clr) | ev;
      m_prev[k] = m_psr[k];
      m_psr[k]  = pin;
      if (v && w) begin
        case (a)
          6'h00: m_dr[k] = d;
          6'h04: m_dir[k] = d;
          6'h0C: m_cfg[k][31:0] = d;
          6'h10: m_cfg[k][63:32] = d;
          6'h14: m_mask[k] = d;
          6'h1C: if (has_edge[k]) m_edge[k] = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare_one(int k, logic [31:0] rd, logic rdy, logic err,
                             logic lo, logic hi, logic [31:0] po, logic [31:0] oe);
    logic [31:0] pend = m_isr[k] & m_mask[k];
    bit exp_lo = split[k] ? (pend[15:0] != 0) : (pend != 0);
    bit exp_hi = split[k] ? (pend[31:16] != 0) : 1'b0;
    string itag = split[k] ? "R9" : "R8";
    cap_rd[k] = rd; cap_err[k] = err; cap_lo[k] = lo; cap_hi[k] = hi;
    if (v && !w) check(read_tag(k, a), "read data", rd, model_read(k, a));
    check("R11", "ready", {31'b0, rdy}, 32'h1);
    check("R11", "addr_err", {31'b0, err}, {31'b0, v && !mapped(a)});
    check(itag, "irq_lo", {31'b0, lo}, {31'b0, exp_lo});
    check(itag, "irq_hi", {31'b0, hi}, {31'b0, exp_hi});
    check("R12", "pin_out", po, m_dr[k]);
    check("R12", "pin_oe", oe, m_dir[k]);
  endtask

  task automatic step();
    #2;
    compare_one(0, rd_a, rdy_a, err_a, lo_a, hi_a, po_a, oe_a);
    compare_one(1, rd_b, rdy_b, err_b, lo_b, hi_b, po_b, oe_b);
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic bus_wr(logic [AW-1:0] ad, logic [31:0] data);
    v = 1; w = 1; a = ad; d = data;
    step();
    v = 0; w = 0; d = 0;
  endtask

  task automatic bus_rd(logic [AW-1:0] ad);
    v = 1; w = 0; a = ad;
    step();
    v = 0;
  endtask

  task automatic idle();
    v = 0; w = 0;
    step();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    bus_rd(6'h18); check("R1", "status after reset", cap_rd[0], 32'h0);
    bus_rd(6'h00); check("R1", "data after reset", cap_rd[0], 32'h0);
    bus_rd(6'h0C); check("R1", "cfg after reset", cap_rd[0], 32'h0);
    bus_rd(6'h14); check("R1", "mask after reset", cap_rd[0], 32'h0);
    check("R1", "pin_out after reset", po_a, 32'h0);
    check("R1", "irq after reset", {31'b0, lo_a | hi_a | lo_b | hi_b}, 32'h0);

    // All pins rising, then clear status
    bus_wr(6'h0C, 32'hAAAA_AAAA);
    bus_wr(6'h10, 32'hAAAA_AAAA);
    bus_wr(6'h18, 32'hFFFF_FFFF);
    bus_rd(6'h18); check("R7", "status cleared", cap_rd[0], 32'h0);

    // Upper half outputs, data merge
    bus_wr(6'h04, 32'hFFFF_0000);
    pin = 32'h1234_5678;
    bus_wr(6'h00, 32'hA5A5_5A5A);
    idle();
    bus_rd(6'h00); check("R2", "merged data", cap_rd[0], 32'hA5A5_5678);
    check("R12", "pin_out", po_a, 32'hA5A5_5A5A);
    check("R12", "pin_oe", oe_a, 32'hFFFF_0000);
    bus_rd(6'h08); check("R3", "pad status", cap_rd[0], 32'h0000_5678);
    bus_rd(6'h18); check("R4", "rising events", cap_rd[0], 32'h0000_5678);
    check("R6", "output pins no events", cap_rd[0] & 32'hFFFF_0000, 32'h0);

    // Partial clear
    bus_wr(6'h18, 32'h0000_0600);
    bus_rd(6'h18); check("R7", "partial clear", cap_rd[0], 32'h0000_5078);

    // Falling on low pins
    bus_wr(6'h0C, 32'hFFFF_FFFF);
    bus_wr(6'h18, 32'hFFFF_FFFF);
    pin = 32'h1234_0000;
    idle();
    idle();
    bus_rd(6'h18); check("R4", "falling events", cap_rd[0], 32'h0000_5678);

    // High level with clear during active level
    bus_wr(6'h0C, 32'h5555_5555);
    bus_wr(6'h18, 32'hFFFF_FFFF);
    pin = 32'h1234_0001;
    idle();
    idle();
    bus_wr(6'h18, 32'h0000_0001);
    bus_rd(6'h18); check("R7", "level survives clear", cap_rd[0], 32'h0000_0001);

    // Interrupt lines
    bus_wr(6'h14, 32'h0000_0001);
    idle();
    check("R8", "single irq", {31'b0, lo_a}, 32'h1);
    check("R9", "split lo", {31'b0, lo_b}, 32'h1);
    check("R9", "split hi", {31'b0, hi_b}, 32'h0);
    bus_wr(6'h04, 32'h0);
    bus_wr(6'h10, 32'h5555_5555);
    bus_wr(6'h14, 32'hFFFF_0000);
    idle();
    idle();
    check("R8", "single irq upper", {31'b0, lo_a}, 32'h1);
    check("R9", "split lo off", {31'b0, lo_b}, 32'h0);
    check("R9", "split hi on", {31'b0, hi_b}, 32'h1);

    // Any-edge override
    bus_wr(6'h0C, 32'hFFFF_FFFF);
    bus_wr(6'h1C, 32'h0000_0002);
    bus_wr(6'h18, 32'hFFFF_FFFF);
    pin = 32'h1234_0003;
    idle();
    idle();
    bus_rd(6'h18);
    check("R5", "any-edge rise", cap_rd[0] & 32'h2, 32'h2);
    check("R10", "no any-edge rise", cap_rd[1] & 32'h2, 32'h0);
    bus_rd(6'h1C);
    check("R5", "edge word", cap_rd[0], 32'h2);
    check("R10", "absent edge word", cap_rd[1], 32'h0);

    // Unmapped and read-only offsets
    bus_wr(6'h20, 32'hFFFF_FFFF); check("R11", "err write", {31'b0, cap_err[0]}, 32'h1);
    bus_rd(6'h24); check("R11", "err read", {31'b0, cap_err[0]}, 32'h1);
    check("R11", "unmapped zero", cap_rd[0], 32'h0);
    bus_rd(6'h02); check("R11", "misaligned err", {31'b0, cap_err[1]}, 32'h1);
    bus_wr(6'h08, 32'hFFFF_FFFF); check("R11", "pad write no err", {31'b0, cap_err[0]}, 32'h0);
    bus_rd(6'h14); check("R11", "mask untouched", cap_rd[0], 32'hFFFF_0000);
    idle();
    check("R11", "idle no err", {31'b0, err_a}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule